// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a host write port and the operation controller of a parallel NOR flash. Each host write carries a word address and a 16-bit data word. The decoder follows the multi-write command sequences a host must issue: a pair of address-qualified unlock writes, then a setup code, then the operand writes. When a sequence completes, it emits a single-cycle command pulse together with the address and data of the write that finished it. Word program, sector erase, chip erase, and the stages of a write-buffer load are all recognised this way. Status read, status clear and reset are single writes that need no unlock.

The operation controller reports a running program or erase through `op_busy`. While that flag is high the decoder accepts only two writes: the status read and the suspend code. Every other write is dropped, and any sequence in progress is abandoned. A suspend is refused while a chip erase runs. After a suspend has been accepted, one resume is honoured, and any further resumes are ignored until the next suspend.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `cmd_valid` is 0 and `cmd_kind`, `cmd_addr` and `cmd_data` are all zero.
- R2: The two unlock writes are data AAh at address 555h, then data 55h at address 2AAh. Address matching uses only the low 11 address bits, and code matching uses only the low data byte. A write that completes a command raises `cmd_valid` for exactly the one cycle after that write. `cmd_addr` and `cmd_data` then hold that write's address and data. Unlock writes produce no pulse.
- R3: The program sequence is the unlock pair, then A0h at 555h, then one write of any address and data. That last write emits `cmd_kind` 1 carrying its address and data.
- R4: The erase sequence is the unlock pair, 80h at 555h, then the unlock pair again. A final 30h at any address then emits `cmd_kind` 2 (sector erase) with that address. A final 10h at 555h instead emits `cmd_kind` 3 (chip erase).
- R5: The buffer load starts with the unlock pair and then 25h at an address that names the sector. The sector is the address bits from bit 16 upward. The next write must be in the same sector and must carry a word count no greater than 255. It emits `cmd_kind` 4 with the count as data.
- R6: After the count write, count+1 data writes inside the sector each emit `cmd_kind` 5. A following 29h in the same sector emits `cmd_kind` 6 (buffer commit).
- R7: Within a buffer load, any of the following emits `cmd_kind` 7 (abort) and returns the decoder to idle: a write outside the sector, a count above 255, or anything other than 29h in the sector at the confirm step.
- R8: From idle, each of these single writes emits its own code: 70h at 555h gives `cmd_kind` 8 (status read), 71h at 555h gives 9 (status clear), and F0h at any address gives 10 (reset).
- R9: A write that does not match the expected step returns the decoder to idle and emits nothing. The next write is decoded from idle.
- R10: While `op_busy` is 1, only 70h at 555h (`cmd_kind` 8) and B0h at any address (`cmd_kind` 11, suspend) can emit. Every other write is ignored, and any partly entered sequence is dropped.
- R11: A suspend is accepted at most once until a resume. It is ignored while the most recent operation command emitted was a chip erase.
- R12: 30h at any address, written from idle while `op_busy` is 0 and a suspend is outstanding, emits `cmd_kind` 12 (resume). At any other time a lone 30h from idle emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | ADDR_W (24) | Word address of the write |
| wr_data | input | DATA_W (16) | Data word of the write |
| op_busy | input | 1 | Program or erase in progress, from the operation controller |
| cmd_valid | output | 1 | Single-cycle command pulse |
| cmd_kind | output | 4 | Command code, as listed in the requirements |
| cmd_addr | output | ADDR_W (24) | Address of the write that completed the command |
| cmd_data | output | DATA_W (16) | Data of the write that completed the command |

## Verification
Every command result is registered. It appears on the clock edge that samples the completing write, so it is visible one cycle after the write is presented. The bench presents each write at the falling edge and reads all four outputs 1 ns after the following rising edge. Both "pulse expected" and "nothing expected" checks are made at that single point after every write. Changes to `op_busy` are also made at a falling edge, so the filter sees them on the same edge as the next write.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [3:0] {
        CMD_NONE         = 4'd0,
        CMD_PROGRAM      = 4'd1,
        CMD_SECTOR_ERASE = 4'd2,
        CMD_CHIP_ERASE   = 4'd3,
        CMD_WBUF_START   = 4'd4,
        CMD_WBUF_WORD    = 4'd5,
        CMD_WBUF_COMMIT  = 4'd6,
        CMD_WBUF_ABORT   = 4'd7,
        CMD_STATUS_READ  = 4'd8,
        CMD_STATUS_CLEAR = 4'd9,
        CMD_RESET        = 4'd10,
        CMD_SUSPEND      = 4'd11,
        CMD_RESUME       = 4'd12
    } cmd_kind_e;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_PROG,
        SQ_ERA1,
        SQ_ERA2,
        SQ_ERA3,
        SQ_WB_CNT,
        SQ_WB_DATA,
        SQ_WB_CONF
    } seq_state_e;

    localparam logic [10:0] UNLOCK_ADDR_A = 11'h555;
    localparam logic [10:0] UNLOCK_ADDR_B = 11'h2AA;

    localparam logic [7:0] CODE_UNLOCK_A = 8'hAA;
    localparam logic [7:0] CODE_UNLOCK_B = 8'h55;
    localparam logic [7:0] CODE_PROGRAM  = 8'hA0;
    localparam logic [7:0] CODE_ERASE    = 8'h80;
    localparam logic [7:0] CODE_SECTOR   = 8'h30;
    localparam logic [7:0] CODE_CHIP     = 8'h10;
    localparam logic [7:0] CODE_WBUF     = 8'h25;
    localparam logic [7:0] CODE_WB_CONF  = 8'h29;
    localparam logic [7:0] CODE_SR_READ  = 8'h70;
    localparam logic [7:0] CODE_SR_CLEAR = 8'h71;
    localparam logic [7:0] CODE_RESET    = 8'hF0;
    localparam logic [7:0] CODE_SUSPEND  = 8'hB0;
    localparam logic [7:0] CODE_RESUME   = 8'h30;

    // Per-write match flags shared by the sequencer
    typedef struct packed {
        logic at_a;
        logic at_b;
        logic d_aa;
        logic d_55;
        logic d_a0;
        logic d_80;
        logic d_30;
        logic d_10;
        logic d_25;
        logic d_29;
        logic d_70;
        logic d_71;
        logic d_f0;
    } cyc_class_t;

endpackage

// File: rtl/fcd_cycle_class.sv
module fcd_cycle_class
    import fcd_pkg::*;
#(
    parameter int UNLOCK_BITS = 11
) (
    input  logic [UNLOCK_BITS-1:0] low_addr,
    input  logic [7:0]             code,
    output cyc_class_t             cls,
    output logic                   is_suspend,
    output logic                   is_resume
);

    always_comb begin
        cls.at_a   = (low_addr == UNLOCK_BITS'(UNLOCK_ADDR_A));
        cls.at_b   = (low_addr == UNLOCK_BITS'(UNLOCK_ADDR_B));
        cls.d_aa   = (code == CODE_UNLOCK_A);
        cls.d_55   = (code == CODE_UNLOCK_B);
        cls.d_a0   = (code == CODE_PROGRAM);
        cls.d_80   = (code == CODE_ERASE);
        cls.d_30   = (code == CODE_SECTOR);
        cls.d_10   = (code == CODE_CHIP);
        cls.d_25   = (code == CODE_WBUF);
        cls.d_29   = (code == CODE_WB_CONF);
        cls.d_70   = (code == CODE_SR_READ);
        cls.d_71   = (code == CODE_SR_CLEAR);
        cls.d_f0   = (code == CODE_RESET);
        is_suspend = (code == CODE_SUSPEND);
        is_resume  = (code == CODE_RESUME);
    end

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import fcd_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int SECT_W    = 8,
    parameter int BUF_WORDS = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              flush,
    input  logic [SECT_W-1:0] wr_sect,
    input  logic [DATA_W-1:0] wr_data,
    input  cyc_class_t        cls,
    output logic              emit_valid,
    output cmd_kind_e         emit_kind,
    output logic              is_idle
);

    localparam int CNT_W = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;
    localparam logic [DATA_W-1:0] CNT_LIMIT = DATA_W'(BUF_WORDS);

    typedef struct packed {
        seq_state_e        st;
        logic [SECT_W-1:0] sect;
        logic [CNT_W-1:0]  left;
    } seq_t;

    seq_t seq_d, seq_q;
    logic same_sect;

    assign same_sect = (wr_sect == seq_q.sect);
    assign is_idle   = (seq_q.st == SQ_IDLE);

    always_comb begin
        seq_d      = seq_q;
        emit_valid = 1'b0;
        emit_kind  = CMD_NONE;
        if (flush) begin
            seq_d.st = SQ_IDLE;
        end else if (wr_en) begin
            // any write that does not match the expected step ends in idle
            seq_d.st = SQ_IDLE;
            unique case (seq_q.st)
                SQ_IDLE: begin
                    if (cls.at_a && cls.d_aa) begin
                        seq_d.st = SQ_UNL1;
                    end else if (cls.at_a && cls.d_70) begin
                        emit_valid = 1'b1;
                        emit_kind  = CMD_STATUS_READ;
                    end else if (cls.at_a && cls.d_71) begin
                        emit_valid = 1'b1;
                        emit_kind  = CMD_STATUS_CLEAR;
                    end else if (cls.d_f0) begin
                        emit_valid = 1'b1;
                        emit_kind  = CMD_RESET;
                    end
                end
                SQ_UNL1: begin
                    if (cls.at_b && cls.d_55) seq_d.st = SQ_UNL2;
                end
                SQ_UNL2: begin
                    if (cls.at_a && cls.d_a0) begin
                        seq_d.st = SQ_PROG;
                    end else if (cls.at_a && cls.d_80) begin
                        seq_d.st = SQ_ERA1;
                    end else if (cls.d_25) begin
                        seq_d.st   = SQ_WB_CNT;
                        seq_d.sect = wr_sect;
                    end
                end
                SQ_PROG: begin
                    emit_valid = 1'b1;
                    emit_kind  = CMD_PROGRAM;
                end
                SQ_ERA1: begin
                    if (cls.at_a && cls.d_aa) seq_d.st = SQ_ERA2;
                end
                SQ_ERA2: begin
                    if (cls.at_b && cls.d_55) seq_d.st = SQ_ERA3;
                end
                SQ_ERA3: begin
                    if (cls.d_30) begin
                        emit_valid = 1'b1;
                        emit_kind  = CMD_SECTOR_ERASE;
                    end else if (cls.at_a && cls.d_10) begin
                        emit_valid = 1'b1;
                        emit_kind  = CMD_CHIP_ERASE;
                    end
                end
                SQ_WB_CNT: begin
                    emit_valid = 1'b1;
                    if (same_sect && (wr_data < CNT_LIMIT)) begin
                        emit_kind  = CMD_WBUF_START;
                        seq_d.st   = SQ_WB_DATA;
                        seq_d.left = wr_data[CNT_W-1:0];
                    end else begin
                        emit_kind  = CMD_WBUF_ABORT;
                    end
                end
                SQ_WB_DATA: begin
                    emit_valid = 1'b1;
                    if (same_sect) begin
                        emit_kind = CMD_WBUF_WORD;
                        if (seq_q.left == '0) begin
                            seq_d.st = SQ_WB_CONF;
                        end else begin
                            seq_d.st   = SQ_WB_DATA;
                            seq_d.left = seq_q.left - 1'b1;
                        end
                    end else begin
                        emit_kind = CMD_WBUF_ABORT;
                    end
                end
                SQ_WB_CONF: begin
                    emit_valid = 1'b1;
                    emit_kind  = (same_sect && cls.d_29) ? CMD_WBUF_COMMIT
                                                         : CMD_WBUF_ABORT;
                end
                default: seq_d.st = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st   <= SQ_IDLE;
            seq_q.sect <= '0;
            seq_q.left <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

endmodule

// File: rtl/fcd_busy_filter.sv
module fcd_busy_filter
    import fcd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic      op_busy,
    input  logic      at_a,
    input  logic      d_70,
    input  logic      is_suspend,
    input  logic      is_resume,
    input  logic      seq_idle,
    input  logic      seq_emit_valid,
    input  cmd_kind_e seq_emit_kind,
    output logic      seq_wr_en,
    output logic      seq_flush,
    output logic      side_valid,
    output cmd_kind_e side_kind,
    output logic      run_is_chip,
    output logic      suspended
);

    typedef struct packed {
        logic susp;
        logic chip;
    } flt_t;

    flt_t flt_d, flt_q;
    logic resume_hit, status_hit, suspend_hit;

    always_comb begin
        resume_hit  = wr_en && !op_busy && flt_q.susp && seq_idle && is_resume;
        status_hit  = wr_en && op_busy && at_a && d_70;
        suspend_hit = wr_en && op_busy && is_suspend && !flt_q.susp && !flt_q.chip;

        seq_flush = op_busy;
        seq_wr_en = wr_en && !op_busy && !resume_hit;

        side_valid = resume_hit || status_hit || suspend_hit;
        if (resume_hit)       side_kind = CMD_RESUME;
        else if (status_hit)  side_kind = CMD_STATUS_READ;
        else if (suspend_hit) side_kind = CMD_SUSPEND;
        else                  side_kind = CMD_NONE;

        flt_d = flt_q;
        if (suspend_hit) flt_d.susp = 1'b1;
        if (resume_hit)  flt_d.susp = 1'b0;
        if (seq_emit_valid) begin
            unique case (seq_emit_kind)
                CMD_CHIP_ERASE:                                  flt_d.chip = 1'b1;
                CMD_PROGRAM, CMD_SECTOR_ERASE, CMD_WBUF_COMMIT: flt_d.chip = 1'b0;
                default: ;
            endcase
        end
    end

    assign run_is_chip = flt_q.chip;
    assign suspended   = flt_q.susp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q.susp <= 1'b0;
            flt_q.chip <= 1'b0;
        end else begin
            flt_q <= flt_d;
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int DATA_W      = 16,
    parameter int UNLOCK_BITS = 11,
    parameter int SECT_LSB    = 16,
    parameter int BUF_WORDS   = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              op_busy,
    output logic              cmd_valid,
    output logic [3:0]        cmd_kind,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data
);

    localparam int SECT_W = ADDR_W - SECT_LSB;

    typedef struct packed {
        logic              valid;
        cmd_kind_e         kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } out_t;

    out_t       out_d, out_q;
    cyc_class_t cls;
    logic       is_suspend, is_resume;
    logic       seq_wr_en, seq_flush, seq_idle, seq_emit_valid;
    cmd_kind_e  seq_emit_kind;
    logic       side_valid;
    cmd_kind_e  side_kind;
    logic       run_is_chip;
    logic       suspended;

    fcd_cycle_class #(
        .UNLOCK_BITS (UNLOCK_BITS)
    ) u_class (
        .low_addr   (wr_addr[UNLOCK_BITS-1:0]),
        .code       (wr_data[7:0]),
        .cls        (cls),
        .is_suspend (is_suspend),
        .is_resume  (is_resume)
    );

    fcd_seq_fsm #(
        .DATA_W    (DATA_W),
        .SECT_W    (SECT_W),
        .BUF_WORDS (BUF_WORDS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (seq_wr_en),
        .flush      (seq_flush),
        .wr_sect    (wr_addr[ADDR_W-1:SECT_LSB]),
        .wr_data    (wr_data),
        .cls        (cls),
        .emit_valid (seq_emit_valid),
        .emit_kind  (seq_emit_kind),
        .is_idle    (seq_idle)
    );

    fcd_busy_filter u_filter (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .op_busy        (op_busy),
        .at_a           (cls.at_a),
        .d_70           (cls.d_70),
        .is_suspend     (is_suspend),
        .is_resume      (is_resume),
        .seq_idle       (seq_idle),
        .seq_emit_valid (seq_emit_valid),
        .seq_emit_kind  (seq_emit_kind),
        .seq_wr_en      (seq_wr_en),
        .seq_flush      (seq_flush),
        .side_valid     (side_valid),
        .side_kind      (side_kind),
        .run_is_chip    (run_is_chip),
        .suspended      (suspended)
    );

    always_comb begin
        out_d = '0;
        if (side_valid || seq_emit_valid) begin
            out_d.valid = 1'b1;
            out_d.kind  = side_valid ? side_kind : seq_emit_kind;
            out_d.addr  = wr_addr;
            out_d.data  = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign cmd_valid = out_q.valid;
    assign cmd_kind  = out_q.kind;
    assign cmd_addr  = out_q.addr;
    assign cmd_data  = out_q.data;

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              op_busy,
    input logic              cmd_valid,
    input logic [3:0]        cmd_kind,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [DATA_W-1:0] cmd_data,
    input logic              run_is_chip
);

    p_pulse_follows_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(wr_en));

    p_program_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 4'd1) |->
            (cmd_addr == $past(wr_addr) && cmd_data == $past(wr_data)));

    p_erase_final_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 4'd2) |-> ($past(wr_data[7:0]) == 8'h30));

    p_busy_filter_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && $past(op_busy)) |-> (cmd_kind == 4'd8 || cmd_kind == 4'd11));

    p_no_chip_suspend_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 4'd11) |-> !$past(run_is_chip));

    p_resume_not_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 4'd12) |-> !$past(op_busy));

endmodule

bind flash_cmd_decoder fcd_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_fcd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .op_busy     (op_busy),
    .cmd_valid   (cmd_valid),
    .cmd_kind    (cmd_kind),
    .cmd_addr    (cmd_addr),
    .cmd_data    (cmd_data),
    .run_is_chip (run_is_chip)
);

// File: tb/flash_cmd_decoder_bench.sv
`timescale 1ns/1ps
module flash_cmd_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [23:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        op_busy = 1'b0;
    logic        cmd_valid;
    logic [3:0]  cmd_kind;
    logic [23:0] cmd_addr;
    logic [15:0] cmd_data;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic        got_v;
    logic [3:0]  got_k;
    logic [23:0] got_a;
    logic [15:0] got_d;

    always #2 clk = ~clk;

    flash_cmd_decoder u_flash_cmd_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .op_busy   (op_busy),
        .cmd_valid (cmd_valid),
        .cmd_kind  (cmd_kind),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data)
    );

    task automatic wr(input logic [23:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        got_v = cmd_valid; got_k = cmd_kind; got_a = cmd_addr; got_d = cmd_data;
        wr_en = 1'b0;
    endtask

    task automatic set_busy(input logic b);
        @(negedge clk);
        op_busy = b;
    endtask

    task automatic expect_cmd(input string req, input int k,
                              input logic [23:0] a, input logic [15:0] d);
        tests++;
        if (!(got_v === 1'b1 && got_k === 4'(k) && got_a === a && got_d === d)) begin
            fails++;
            $display("FAIL %s: got v=%0b kind=%0d addr=%h data=%h, expected v=1 kind=%0d addr=%h data=%h",
                     req, got_v, got_k, got_a, got_d, k, a, d);
        end
    endtask

    task automatic expect_none(input string req);
        tests++;
        if (got_v !== 1'b0) begin
            fails++;
            $display("FAIL %s: got v=%0b kind=%0d, expected v=0", req, got_v, got_k);
        end
    endtask

    task automatic unlock(input string req);
        wr(24'h000555, 16'h00AA); expect_none(req);
        wr(24'h0002AA, 16'h0055); expect_none(req);
    endtask

    task automatic t_reset_state();
        @(posedge clk); #1;
        tests++;
        if (cmd_valid !== 1'b0 || cmd_kind !== 4'd0 || cmd_addr !== '0 || cmd_data !== '0) begin
            fails++;
            $display("FAIL R1: got v=%0b kind=%0d addr=%h data=%h, expected all zero",
                     cmd_valid, cmd_kind, cmd_addr, cmd_data);
        end
    endtask

    task automatic t_program();
        // R2: upper address bits and upper data byte ignored in unlock
        wr(24'h3A0555, 16'h12AA); expect_none("R2");
        wr(24'h1F02AA, 16'hFF55); expect_none("R2");
        wr(24'h000555, 16'h00A0); expect_none("R3");
        wr(24'h012345, 16'hBEEF); expect_cmd("R3", 1, 24'h012345, 16'hBEEF);
        @(posedge clk); #1;
        got_v = cmd_valid;
        expect_none("R2");
    endtask

    task automatic t_erase();
        unlock("R4");
        wr(24'h000555, 16'h0080); expect_none("R4");
        unlock("R4");
        wr(24'h070123, 16'h0030); expect_cmd("R4", 2, 24'h070123, 16'h0030);
        unlock("R4");
        wr(24'h000555, 16'h0080); expect_none("R4");
        unlock("R4");
        wr(24'h000555, 16'h0010); expect_cmd("R4", 3, 24'h000555, 16'h0010);
    endtask

    task automatic t_mismatch();
        wr(24'h000555, 16'h00AA); expect_none("R9");
        wr(24'h0002AB, 16'h0055); expect_none("R9");
        wr(24'h000555, 16'h00A0); expect_none("R9");
        wr(24'h000100, 16'h1234); expect_none("R9");
        wr(24'h000556, 16'h00AA); expect_none("R9");
        wr(24'h0002AA, 16'h0055); expect_none("R9");
        wr(24'h000555, 16'h00A0); expect_none("R9");
        wr(24'h000200, 16'h5678); expect_none("R9");
        unlock("R9");
        wr(24'h000555, 16'h00A0); expect_none("R9");
        wr(24'h000200, 16'h5678); expect_cmd("R9", 1, 24'h000200, 16'h5678);
    endtask

    task automatic t_single();
        wr(24'h000555, 16'h0070); expect_cmd("R8", 8, 24'h000555, 16'h0070);
        wr(24'h400555, 16'h0071); expect_cmd("R8", 9, 24'h400555, 16'h0071);
        wr(24'h123456, 16'h00F0); expect_cmd("R8", 10, 24'h123456, 16'h00F0);
        wr(24'h000556, 16'h0070); expect_none("R8");
    endtask

    task automatic t_wbuf();
        unlock("R5");
        wr(24'h050000, 16'h0025); expect_none("R5");
        wr(24'h050000, 16'h0002); expect_cmd("R5", 4, 24'h050000, 16'h0002);
        for (int i = 0; i < 3; i++) begin
            wr(24'h050010 + 24'(i), 16'hA000 + 16'(i));
            expect_cmd("R6", 5, 24'h050010 + 24'(i), 16'hA000 + 16'(i));
        end
        wr(24'h050000, 16'h0029); expect_cmd("R6", 6, 24'h050000, 16'h0029);
        // word outside the sector
        unlock("R7");
        wr(24'h050000, 16'h0025); expect_none("R7");
        wr(24'h050000, 16'h0003); expect_cmd("R7", 4, 24'h050000, 16'h0003);
        wr(24'h060010, 16'h1111); expect_cmd("R7", 7, 24'h060010, 16'h1111);
        wr(24'h050011, 16'h2222); expect_none("R7");
        // count too large
        unlock("R7");
        wr(24'h050000, 16'h0025); expect_none("R7");
        wr(24'h050000, 16'h0100); expect_cmd("R7", 7, 24'h050000, 16'h0100);
        // wrong confirm
        unlock("R7");
        wr(24'h050000, 16'h0025); expect_none("R7");
        wr(24'h050000, 16'h0000); expect_cmd("R7", 4, 24'h050000, 16'h0000);
        wr(24'h05FFFF, 16'h3333); expect_cmd("R6", 5, 24'h05FFFF, 16'h3333);
        wr(24'h050000, 16'h0030); expect_cmd("R7", 7, 24'h050000, 16'h0030);
    endtask

    task automatic t_busy();
        unlock("R10");
        wr(24'h000555, 16'h0080); expect_none("R10");
        unlock("R10");
        wr(24'h000555, 16'h0010); expect_cmd("R10", 3, 24'h000555, 16'h0010);
        set_busy(1'b1);
        wr(24'h000000, 16'h00B0); expect_none("R11");
        wr(24'h000555, 16'h0070); expect_cmd("R10", 8, 24'h000555, 16'h0070);
        wr(24'h000555, 16'h0071); expect_none("R10");
        wr(24'h000000, 16'h00F0); expect_none("R10");
        wr(24'h000555, 16'h00AA); expect_none("R10");
        set_busy(1'b0);
        wr(24'h0002AA, 16'h0055); expect_none("R10");
        wr(24'h000555, 16'h00A0); expect_none("R10");
        wr(24'h000100, 16'h4444); expect_none("R10");
    endtask

    task automatic t_suspend_resume();
        wr(24'h000000, 16'h0030); expect_none("R12");
        unlock("R11");
        wr(24'h000555, 16'h0080); expect_none("R11");
        unlock("R11");
        wr(24'h020000, 16'h0030); expect_cmd("R11", 2, 24'h020000, 16'h0030);
        set_busy(1'b1);
        wr(24'h000777, 16'h00B0); expect_cmd("R11", 11, 24'h000777, 16'h00B0);
        wr(24'h000777, 16'h00B0); expect_none("R11");
        set_busy(1'b0);
        wr(24'h000000, 16'h0030); expect_cmd("R12", 12, 24'h000000, 16'h0030);
        wr(24'h000000, 16'h0030); expect_none("R12");
        set_busy(1'b1);
        wr(24'h000001, 16'h00B0); expect_cmd("R11", 11, 24'h000001, 16'h00B0);
        set_busy(1'b0);
        wr(24'h000555, 16'h00AA); expect_none("R12");
        wr(24'h000000, 16'h0030); expect_none("R12");
        wr(24'h000000, 16'h0030); expect_cmd("R12", 12, 24'h000000, 16'h0030);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_program();
        t_erase();
        t_mismatch();
        t_single();
        t_wbuf();
        t_busy();
        t_suspend_resume();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule